// File: doc/BRIEF.md
# Memory Copy Engine with CRC Trailer

This coprocessor moves a byte array from one place in an 8-bit data space to another and, while it moves the bytes, folds each of them into a 16-bit CRC. When the last byte has been written, the engine stores the CRC as two trailer bytes directly after the destination array. A processor sets up the transfer by writing three configuration registers (source pointer, destination pointer, byte count) through a small register port. Any write to the command/status offset then starts the engine.

While the transfer runs, the engine owns a single-port, synchronous-read RAM. It raises a busy flag that the processor uses as a stall. The copy is pipelined: after one priming cycle, each byte takes one read cycle followed by one write cycle. A transfer of L bytes holds busy for exactly 2L+6 cycles. Of those, two are start-up cycles, 2L carry the copy, and four handle the CRC settle, the two trailer writes and a closing cycle.

Top module: `mcpy_engine`

## Requirements
- R1: Register offsets are 0x0 source pointer, 0x1 destination pointer and 0x2 byte count. Each is 8 bits, resets to 0 and reads back what was last written while idle.
- R2: A write of any data to offset 0xF while idle starts a transfer. A read of offset 0xF returns the busy flag in bit 0, with all other bits 0.
- R3: Busy rises in the cycle after the start write and stays high for exactly 2L+6 cycles, where L is the byte count.
- R4: Source byte i (i = 0..L-1) is copied to destination address dst+i. All addresses wrap modulo 256. Each byte is read in one cycle and written in the next.
- R5: The CRC uses polynomial 0x1021, initial value 0xFFFF, most-significant bit first and no final inversion. For the nine bytes "123456789" it is 0x29B1.
- R6: The CRC high byte is written to dst+L and the low byte to dst+L+1. No other memory location changes.
- R7: A byte count of 0 copies nothing and writes only the trailer 0xFF, 0xFF at dst and dst+1.
- R8: Register writes, including writes to offset 0xF, are ignored while busy. They do not change any configuration value and do not restart the engine.
- R9: The memory port is silent while idle. A read presented with mem_en=1 and mem_we=0 returns its data on mem_rdata in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational on cfg_addr) |
| busy | output | 1 | Transfer in progress; stalls the processor |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the read |

## Verification
Busy is due one cycle after the start write. It is counted on falling edges until it drops, and the count is compared with 2L+6 for every length swept from 0 to 24, plus a 100-byte transfer and two transfers whose addresses wrap. Memory is examined only after busy has fallen. At that point the whole 256-byte image is compared with the arithmetically expected one, so copied bytes, both trailer bytes and untouched locations are all final. Register readback and the CSR busy bit are combinational and are sampled shortly after the falling edge that follows the access. Writes injected during busy are checked by reading the registers back afterwards and confirming that busy stays low one cycle after it falls.

// File: rtl/mcpy_pkg.sv
package mcpy_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int OFS_W    = 4;
    localparam int CRC_W    = 16;
    localparam int N_CFG    = 3;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    localparam logic [OFS_W-1:0] OFS_CSR  = 4'hF;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CRC_W-1:0]  crc_t;

    typedef struct packed {
        addr_t src;
        addr_t dst;
        addr_t len;
    } cfg_t;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_PRIME, S_RD, S_WR, S_SETTLE, S_WCH, S_WCL, S_FIN
    } seq_state_e;

    function automatic crc_t crc_step(crc_t c, byte_t d);
        crc_t r;
        r = c ^ (crc_t'(d) << (CRC_W - DATA_W));
        for (int b = 0; b < DATA_W; b++)
            r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        return r;
    endfunction
endpackage

// File: rtl/mcpy_cfg.sv
module mcpy_cfg
    import mcpy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [OFS_W-1:0] addr,
    input  byte_t            wdata,
    input  logic             busy,
    output byte_t            rdata,
    output cfg_t             cfg,
    output logic             start
);
    addr_t regs [N_CFG];

    for (genvar i = 0; i < N_CFG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr && !busy && addr == OFS_W'(i))
                regs[i] <= wdata;
        end
    end

    assign cfg   = '{src: regs[0], dst: regs[1], len: regs[2]};
    assign start = wr && !busy && (addr == OFS_CSR);

    always_comb begin
        rdata = '0;
        if (addr == OFS_CSR)
            rdata = byte_t'(busy);
        else if (addr < OFS_W'(N_CFG))
            rdata = regs[addr[1:0]];
    end

    // R8: configuration holds steady whenever a transfer is running
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));
    // R3: a start write raises busy in the next cycle
    a_r3_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

// File: rtl/mcpy_crc.sv
module mcpy_crc
    import mcpy_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  en,
    input  byte_t din,
    output crc_t  crc
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= CRC_INIT;
        else if (en)
            crc <= crc_step(crc, din);
    end

    // R5: the checksum only moves when a byte is folded in
    a_r5_crc_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(crc));
endmodule

// File: rtl/mcpy_seq.sv
module mcpy_seq
    import mcpy_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  cfg_t  cfg,
    input  byte_t mem_rdata,
    input  crc_t  crc,
    output logic  busy,
    output logic  mem_en,
    output logic  mem_we,
    output addr_t mem_addr,
    output byte_t mem_wdata,
    output logic  crc_clr,
    output logic  crc_en
);
    seq_state_e state;
    addr_t      rptr, wptr, remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            rptr   <= '0;
            wptr   <= '0;
            remain <= '0;
        end else begin
            unique case (state)
                S_IDLE:   if (start) state <= S_LOAD;
                S_LOAD: begin
                    rptr   <= cfg.src;
                    wptr   <= cfg.dst;
                    remain <= cfg.len;
                    state  <= S_PRIME;
                end
                S_PRIME:  state <= (remain == '0) ? S_SETTLE : S_RD;
                S_RD: begin
                    rptr  <= rptr + 1'b1;
                    state <= S_WR;
                end
                S_WR: begin
                    wptr   <= wptr + 1'b1;
                    remain <= remain - 1'b1;
                    state  <= (remain == addr_t'(1)) ? S_SETTLE : S_RD;
                end
                S_SETTLE: state <= S_WCH;
                S_WCH: begin
                    wptr  <= wptr + 1'b1;
                    state <= S_WCL;
                end
                S_WCL:    state <= S_FIN;
                S_FIN:    state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = wptr;
        mem_wdata = mem_rdata;
        crc_clr   = (state == S_LOAD);
        crc_en    = (state == S_WR);
        unique case (state)
            S_RD:  begin mem_en = 1'b1; mem_addr = rptr; end
            S_WR:  begin mem_en = 1'b1; mem_we = 1'b1; end
            S_WCH: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = crc[CRC_W-1 -: DATA_W]; end
            S_WCL: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = crc[DATA_W-1:0]; end
            default: ;
        endcase
    end

    // R9: no memory traffic while idle
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);
    // R4: every copy read is followed at once by a write
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> (mem_en && mem_we));
    // R6: the low trailer byte follows directly after the high trailer byte
    a_r6_trailer_order: assert property (@(posedge clk) disable iff (rst)
        (state == S_WCH) |=> (state == S_WCL && mem_addr == $past(mem_addr) + 1'b1));
    // R7: all bytes consumed before the trailer starts
    a_r7_count_spent: assert property (@(posedge clk) disable iff (rst)
        (state == S_SETTLE) |-> (remain == '0));
endmodule

// File: rtl/mcpy_engine.sv
module mcpy_engine
    import mcpy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [3:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       busy,
    output logic       mem_en,
    output logic       mem_we,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata
);
    cfg_t cfg;
    logic start, crc_clr, crc_en;
    crc_t crc;

    mcpy_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .busy(busy), .rdata(cfg_rdata), .cfg(cfg), .start(start)
    );

    mcpy_crc u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(mem_rdata), .crc(crc)
    );

    mcpy_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg), .mem_rdata(mem_rdata),
        .crc(crc), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .crc_clr(crc_clr), .crc_en(crc_en)
    );
endmodule

// File: tb/sim_mcpy_engine.sv
module sim_mcpy_engine;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [3:0] cfg_addr;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       busy, mem_en, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;

    logic [7:0] ram  [256];
    logic [7:0] snap [256];
    logic [7:0] expv [256];
    int n_chk = 0, n_bad = 0;
    int unsigned seed = 32'h1234_5678;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcpy_engine u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // R9: single-port RAM model with one cycle of read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int base, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = snap[8'(base + i)];
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ d[b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_copy(input int src, input int dst, input int len,
                            input bit poke, input bit vec);
        logic [15:0] crc;
        int cnt, bad, first;
        for (int i = 0; i < 256; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            ram[i] = seed[23:16];
        end
        if (vec) for (int i = 0; i < 9; i++) ram[8'(src + i)] = 8'(8'h31 + i);
        for (int i = 0; i < 256; i++) snap[i] = ram[i];
        crc = ref_crc(src, len);
        for (int i = 0; i < 256; i++) expv[i] = snap[i];
        for (int i = 0; i < len; i++) expv[8'(dst + i)] = snap[8'(src + i)];
        expv[8'(dst + len)]     = crc[15:8];
        expv[8'(dst + len + 1)] = crc[7:0];

        cfg_write(4'h0, 8'(src));
        cfg_write(4'h1, 8'(dst));
        cfg_write(4'h2, 8'(len));
        cfg_write(4'hF, 8'h00);
        cfg_addr = 4'hF;
        #1;
        check(cfg_rdata == 8'h01, "R2", "csr busy bit while running", cfg_rdata, 1);
        cnt = 0;
        while (busy && cnt < 2000) begin
            cnt++;
            if (poke) begin
                if (cnt == 2) begin cfg_wr = 1'b1; cfg_addr = 4'h0; cfg_wdata = ~8'(src); end
                if (cnt == 3) begin cfg_addr = 4'hF; end
                if (cnt == 4) begin cfg_wr = 1'b0; end
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        check(cnt == 2 * len + 6, "R3", $sformatf("busy length L=%0d", len), cnt, 2 * len + 6);
        @(negedge clk);
        check(!busy, "R8", "no restart after finish", busy, 0);
        bad = 0; first = -1;
        for (int i = 0; i < len; i++)
            if (ram[8'(dst + i)] !== snap[8'(src + i)]) begin bad++; if (first < 0) first = i; end
        check(bad == 0, "R4", $sformatf("copied bytes L=%0d first bad idx", len), first, -1);
        check(ram[8'(dst + len)] === crc[15:8], "R6", "trailer high byte",
              ram[8'(dst + len)], crc[15:8]);
        check(ram[8'(dst + len + 1)] === crc[7:0], "R6", "trailer low byte",
              ram[8'(dst + len + 1)], crc[7:0]);
        if (len == 0)
            check(crc == 16'hFFFF && ram[8'(dst)] === 8'hFF && ram[8'(dst + 1)] === 8'hFF,
                  "R7", "empty trailer", {ram[8'(dst)], ram[8'(dst + 1)]}, 16'hFFFF);
        if (vec)
            check({ram[8'(dst + 9)], ram[8'(dst + 10)]} === 16'h29B1, "R5",
                  "check value of 123456789", {ram[8'(dst + 9)], ram[8'(dst + 10)]}, 16'h29B1);
        bad = 0; first = -1;
        for (int i = 0; i < 256; i++)
            if (ram[i] !== expv[i]) begin bad++; if (first < 0) first = i; end
        check(bad == 0, "R6", "whole memory image first bad addr", first, -1);
        cfg_addr = 4'h0; #1;
        check(cfg_rdata == 8'(src), "R8", "source pointer after busy writes", cfg_rdata, src);
        cfg_addr = 4'h2; #1;
        check(cfg_rdata == 8'(len), "R1", "count readback", cfg_rdata, len);
        cfg_addr = 4'hF; #1;
        check(cfg_rdata == 8'h00, "R2", "csr idle", cfg_rdata, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 4'h0; cfg_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_en, "R9", "idle after reset", {busy, mem_en}, 0);
        for (int a = 0; a < 3; a++) begin
            cfg_addr = 4'(a); #1;
            check(cfg_rdata == 8'h00, "R1", $sformatf("reset value offset %0d", a), cfg_rdata, 0);
        end
        cfg_write(4'h1, 8'hA5);
        cfg_addr = 4'h1; #1;
        check(cfg_rdata == 8'hA5, "R1", "destination readback", cfg_rdata, 8'hA5);
        check(!busy, "R2", "config write does not start", busy, 0);

        for (int l = 0; l <= 24; l++) run_copy(8'h10, 8'h80, l, 1'b0, 1'b0);
        run_copy(8'h20, 8'h90, 9, 1'b0, 1'b1);
        run_copy(8'hF8, 8'h40, 12, 1'b0, 1'b0);
        run_copy(8'h60, 8'hFC, 5, 1'b0, 1'b0);
        run_copy(8'h00, 8'h70, 100, 1'b0, 1'b0);
        run_copy(8'h08, 8'hA0, 3, 1'b1, 1'b0);
        run_copy(8'h08, 8'hA0, 0, 1'b1, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule